// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a real address through a small array of block translation entries that software loads. Each entry is a pair of 32-bit words, an upper word that gives the effective block base, the block length and two enables (one for user mode, one for supervisor mode), and a lower word that gives the real block base and a 2-bit protection code. Two independent sets of entries exist. Instruction fetches search one set and every other access searches the other.

A lookup enters as a valid/ready request carrying the effective address, a fetch flag and a user flag. One cycle later the result leaves as a valid/ready response: a hit flag, the page-aligned real address and read/write/execute permission bits. The response register holds its value while `rsp_ready` is low. `req_ready` is high whenever the response register is empty or is being drained in the same cycle, so a new request is accepted only when its result has a place to go. The block does not judge whether an access is allowed and raises no faults. A surrounding translation controller uses the permission bits for that. The number of entries per set is the parameter `N_ENT`.

Entries are written through a plain configuration port, one word per cycle. A write takes effect at the clock edge. A lookup accepted at that same edge sees the old contents.

Top module: `bat_xlate`

## Requirements
- R1: A request with `req_ifetch`=1 searches only the fetch-side entry set. A request with `req_ifetch`=0 searches only the data-side set.
- R2: Upper-word bit 0 enables an entry for user requests (`req_user`=1) and bit 1 enables it for supervisor requests (`req_user`=0). An entry whose enable is clear for the request's mode never hits.
- R3: The entry mask is 0xFFFE0000 with the 11-bit length field (upper bits 12..2) shifted left by 15 cleared from it. Length 0 gives a 128 KiB block and length 0x7FF gives a 256 MiB block.
- R4: An enabled entry hits when (ea AND mask) equals (upper AND 0xFFFE0000). An address outside the block misses.
- R5: On a hit, `rsp_raddr` = ((lower AND mask) OR (ea AND NOT mask)) with bits 11..0 forced to zero.
- R6: When several entries hit, the lowest-numbered one supplies the response.
- R7: `rsp_perm` is {read, write, execute} from lower bits 1..0: code 0 gives 000, code 2 gives 111, and codes 1 and 3 give 101.
- R8: On a miss, `rsp_hit`, `rsp_raddr` and `rsp_perm` are all zero.
- R9: A request accepted at an edge produces `rsp_valid`=1 from that edge onward. While `rsp_valid`=1 and `rsp_ready`=0, the response is held unchanged and `req_ready` is 0.
- R10: Reset clears every entry, so no lookup hits until software writes one.
- R11: A write with `cfg_we`=1 stores `cfg_wdata` in entry `cfg_idx` of the fetch side (`cfg_iside`=1) or the data side (`cfg_iside`=0), in the upper word (`cfg_hi`=1) or the lower word (`cfg_hi`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_iside | input | 1 | 1 selects the fetch-side set, 0 the data-side set |
| cfg_hi | input | 1 | 1 selects the upper word, 0 the lower word |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_ea | input | 32 | Effective address |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_user | input | 1 | Request is made in user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | An entry matched |
| rsp_raddr | output | 32 | Page-aligned real address |
| rsp_perm | output | 3 | Permission bits {read, write, execute} |

## Verification
The assertions assume that `rsp_ready` and the request fields behave as a well-formed stream. A consumer may hold `rsp_ready` low for any number of cycles, and a producer keeps the request contents steady while it waits. The hold check depends only on the block, but the unconditional acceptance property assumes `req_valid` is sampled with `req_ready`. The bench drives requests and configuration writes on the falling edge and samples after the rising edge. It raises back-pressure only in the dedicated scenario, and it writes entries only while no request is pending, so every lookup's expected result is fixed by the entry contents at that time.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned LEN_LSB   = 2;
  localparam int unsigned LEN_W     = 11;
  localparam int unsigned LEN_SHIFT = 15;
  localparam int unsigned EN_USER   = 0;
  localparam int unsigned EN_SUPV   = 1;
  localparam logic [WORD_W-1:0] BASE_MASK = 32'hFFFE_0000;
  localparam logic [WORD_W-1:0] PAGE_MASK = ~((WORD_W)'((1 << PAGE_BITS) - 1));

  // {read, write, execute}
  typedef logic [2:0] perm_t;

  function automatic perm_t code_to_perm(input logic [1:0] code);
    case (code)
      2'd0:    return 3'b000;
      2'd2:    return 3'b111;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] len_to_mask(input logic [WORD_W-1:0] up);
    logic [WORD_W-1:0] grow;
    grow = (WORD_W)'(up[LEN_LSB +: LEN_W]) << (LEN_LSB + LEN_SHIFT);
    return BASE_MASK & ~grow;
  endfunction
endpackage

// File: rtl/bat_bank.sv
module bat_bank #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     hi,
  input  logic [IDX_W-1:0]         idx,
  input  logic [31:0]              wdata,
  output logic [N_ENT-1:0][31:0]   up_words,
  output logic [N_ENT-1:0][31:0]   lo_words
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel;
    assign sel = we && (idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        up_words[e] <= '0;
        lo_words[e] <= '0;
      end else if (sel) begin
        if (hi) up_words[e] <= wdata;
        else    lo_words[e] <= wdata;
      end
    end
  end
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
(
  input  logic [31:0] up_word,
  input  logic [31:0] lo_word,
  input  logic [31:0] ea,
  input  logic        user,
  output logic        hit,
  output logic [31:0] raddr,
  output perm_t       perm
);
  logic        enabled;
  logic [31:0] mask;

  always_comb begin
    enabled = user ? up_word[EN_USER] : up_word[EN_SUPV];
    mask    = enabled ? len_to_mask(up_word) : '0;
    hit     = (mask != '0) && ((ea & mask) == (up_word & BASE_MASK));
    raddr   = ((lo_word & mask) | (ea & ~mask)) & PAGE_MASK;
    perm    = code_to_perm(lo_word[1:0]);
  end
endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick
  import bat_pkg::*;
#(
  parameter int unsigned N_ENT = 4
) (
  input  logic [N_ENT-1:0]         hits,
  input  logic [N_ENT-1:0][31:0]   raddrs,
  input  logic [N_ENT-1:0][2:0]    perms,
  output logic                     any_hit,
  output logic [31:0]              raddr,
  output perm_t                    perm
);
  always_comb begin
    any_hit = 1'b0;
    raddr   = '0;
    perm    = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (hits[e]) begin
        any_hit = 1'b1;
        raddr   = raddrs[e];
        perm    = perms[e];
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_iside,
  input  logic             cfg_hi,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_ea,
  input  logic             req_ifetch,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [31:0]      rsp_raddr,
  output logic [2:0]       rsp_perm
);
  // side 0 = data, side 1 = fetch
  logic [1:0][N_ENT-1:0][31:0] side_up;
  logic [1:0][N_ENT-1:0][31:0] side_lo;

  for (genvar s = 0; s < 2; s++) begin : g_side
    bat_bank #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we && (cfg_iside == s[0])),
      .hi       (cfg_hi),
      .idx      (cfg_idx),
      .wdata    (cfg_wdata),
      .up_words (side_up[s]),
      .lo_words (side_lo[s])
    );
  end

  logic [N_ENT-1:0][31:0] cur_up;
  logic [N_ENT-1:0][31:0] cur_lo;
  assign cur_up = side_up[req_ifetch];
  assign cur_lo = side_lo[req_ifetch];

  logic [N_ENT-1:0]       ent_hit;
  logic [N_ENT-1:0][31:0] ent_raddr;
  logic [N_ENT-1:0][2:0]  ent_perm;

  for (genvar e = 0; e < N_ENT; e++) begin : g_match
    bat_entry_match u_match (
      .up_word (cur_up[e]),
      .lo_word (cur_lo[e]),
      .ea      (req_ea),
      .user    (req_user),
      .hit     (ent_hit[e]),
      .raddr   (ent_raddr[e]),
      .perm    (ent_perm[e])
    );
  end

  logic        sel_hit;
  logic [31:0] sel_raddr;
  perm_t       sel_perm;

  bat_prio_pick #(.N_ENT(N_ENT)) u_pick (
    .hits    (ent_hit),
    .raddrs  (ent_raddr),
    .perms   (ent_perm),
    .any_hit (sel_hit),
    .raddr   (sel_raddr),
    .perm    (sel_perm)
  );

  logic take;
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_raddr <= '0;
      rsp_perm  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= sel_hit;
      rsp_raddr <= sel_hit ? sel_raddr : '0;
      rsp_perm  <= sel_hit ? sel_perm : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

module bat_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic [31:0] rsp_raddr,
  input logic [2:0]  rsp_perm
);
  logic wrote_any;
  always_ff @(posedge clk) begin
    if (!rst_n) wrote_any <= 1'b0;
    else if (cfg_we) wrote_any <= 1'b1;
  end

  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_raddr == '0 && rsp_perm == '0));

  a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_raddr[11:0] == '0));

  a_r7_perm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_perm[2] == rsp_perm[0]) && (!rsp_perm[1] || rsp_perm[2])));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
                                   && $stable(rsp_raddr) && $stable(rsp_perm)));

  a_r9_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r10_no_hit_unprogrammed: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> wrote_any);
endmodule

bind bat_xlate bat_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_raddr (rsp_raddr),
  .rsp_perm  (rsp_perm)
);

// File: tb/bat_xlate_tb_top.sv
module bat_xlate_tb_top;
  localparam int N     = 4;
  localparam int IW    = 2;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_iside = 1'b0, cfg_hi = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_ifetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_hit;
  logic [31:0] rsp_raddr;
  logic [2:0] rsp_perm;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_up [2][N];
  logic [31:0] m_lo [2][N];

  always #(CLK_P/2) clk = ~clk;

  bat_xlate #(.N_ENT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_iside(cfg_iside),
    .cfg_hi(cfg_hi), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_ifetch(req_ifetch), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_raddr(rsp_raddr),
    .rsp_perm(rsp_perm));

  // expected result {hit, perm, raddr} from the requirement text
  function automatic logic [35:0] model(input logic [31:0] ea, input logic f, input logic u);
    for (int e = 0; e < N; e++) begin
      logic [31:0] up, lo, msk, ra;
      logic [2:0] pm;
      up = m_up[f][e];
      lo = m_lo[f][e];
      if ((u && up[0]) || (!u && up[1])) begin
        msk = 32'hFFFE_0000 & ~({21'd0, up[12:2]} << 17);
        if ((ea & msk) == (up & 32'hFFFE_0000)) begin
          ra = ((lo & msk) | (ea & ~msk)) & 32'hFFFF_F000;
          pm = (lo[1:0] == 2'd0) ? 3'b000 : (lo[1:0] == 2'd2) ? 3'b111 : 3'b101;
          return {1'b1, pm, ra};
        end
      end
    end
    return 36'd0;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic side, input int idx, input logic hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_iside = side; cfg_idx = IW'(idx); cfg_hi = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (hi) m_up[side][idx] = d;
    else    m_lo[side][idx] = d;
  endtask

  task automatic entry(input logic side, input int idx, input logic [31:0] up, input logic [31:0] lo);
    wr(side, idx, 1'b1, up);
    wr(side, idx, 1'b0, lo);
  endtask

  task automatic look(input string tag, input logic [31:0] ea, input logic f, input logic u);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_ifetch = f; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, {35'd0, rsp_valid}, 36'd1);
    chk(tag, {rsp_hit, rsp_perm, rsp_raddr}, model(ea, f, u));
  endtask

  task automatic t_reset;
    chk("R9 idle ready", {34'd0, req_ready, rsp_valid}, 36'd2);
    look("R10 data miss after reset", 32'h1000_0000, 1'b0, 1'b0);
    look("R10 fetch miss after reset", 32'h0000_0000, 1'b1, 1'b1);
    chk("R8 miss zero", {rsp_hit, rsp_perm, rsp_raddr}, 36'd0);
  endtask

  task automatic t_side;
    entry(1'b1, 0, 32'h1000_0003, 32'h8000_0002);
    look("R1 fetch side hit", 32'h1001_2345, 1'b1, 1'b0);
    chk("R5 splice", {4'd0, rsp_raddr}, {4'd0, 32'h8001_2000});
    look("R1 data side miss", 32'h1001_2345, 1'b0, 1'b0);
    entry(1'b0, 0, 32'h1000_0003, 32'h4000_0001);
    look("R11 data side write", 32'h1001_2345, 1'b0, 1'b0);
    chk("R11 data raddr", {rsp_hit, rsp_perm, rsp_raddr}, {1'b1, 3'b101, 32'h4001_2000});
  endtask

  task automatic t_valid;
    entry(1'b0, 1, 32'h2000_0002, 32'h6000_0002);
    look("R2 supervisor enabled", 32'h2000_4000, 1'b0, 1'b0);
    look("R2 user disabled", 32'h2000_4000, 1'b0, 1'b1);
    entry(1'b0, 2, 32'h3000_0001, 32'h6200_0002);
    look("R2 user enabled", 32'h3001_F000, 1'b0, 1'b1);
    look("R2 supervisor disabled", 32'h3001_F000, 1'b0, 1'b0);
  endtask

  task automatic t_mask;
    entry(1'b0, 3, 32'h5000_1FFF, 32'h9000_0002);
    look("R3 largest block", 32'h5ABC_DEF7, 1'b0, 1'b0);
    chk("R3 largest raddr", {4'd0, rsp_raddr}, {4'd0, 32'h9ABC_D000});
    wr(1'b0, 3, 1'b1, 32'h5000_000F);
    look("R3 512K inside", 32'h5007_FFFF, 1'b0, 1'b1);
    look("R4 512K outside", 32'h5008_0000, 1'b0, 1'b1);
    look("R4 base mismatch", 32'h6000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_prio;
    entry(1'b1, 2, 32'h7000_0003, 32'hA000_0003);
    entry(1'b1, 1, 32'h7000_0003, 32'hB000_0002);
    look("R6 lowest wins", 32'h7000_1000, 1'b1, 1'b0);
    chk("R6 entry1 raddr", {rsp_hit, rsp_perm, rsp_raddr}, {1'b1, 3'b111, 32'hB000_1000});
    wr(1'b1, 1, 1'b1, 32'h0);
    look("R6 next entry", 32'h7000_1000, 1'b1, 1'b0);
  endtask

  task automatic t_pp;
    for (int c = 0; c < 4; c++) begin
      wr(1'b0, 0, 1'b0, 32'h4000_0000 | c);
      look("R7 protection code", 32'h1000_0000, 1'b0, 1'b0);
    end
  endtask

  task automatic t_bp;
    logic [35:0] first;
    first = model(32'h1000_0000, 1'b0, 1'b0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ea = 32'h1000_0000; req_ifetch = 1'b0; req_user = 1'b0;
    @(negedge clk);
    req_ea = 32'h5007_0000; req_user = 1'b1;
    chk("R9 stall ready low", {34'd0, rsp_valid, req_ready}, 36'd2);
    @(negedge clk);
    chk("R9 held response", {rsp_hit, rsp_perm, rsp_raddr}, first);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second after drain", {rsp_hit, rsp_perm, rsp_raddr}, model(32'h5007_0000, 1'b0, 1'b1));
    @(negedge clk);
    chk("R9 drained", {35'd0, rsp_valid}, 36'd0);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < N; e++) begin m_up[s][e] = '0; m_lo[s][e] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_side();
    t_valid();
    t_mask();
    t_prio();
    t_pp();
    t_bp();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule